// File: doc/BRIEF.md
# Sharp panel control signal sequencer

This block produces the three per-line control strobes of a Sharp-style TFT panel: a line clock strobe (`cls`), a polarity-select strobe (`ps`) and a line-alternating reversal signal (`rev`). A line-start pulse starts each line. From then on the block counts line-shift clock periods, which arrive as single-cycle `lsclk_en` pulses. Programmable delays in one 32-bit configuration word decide where each edge falls. `cls` rises after its own delay and stays high for a fixed number of periods. `ps` rises a programmed number of periods after `cls` falls. `rev` flips once per line after its own delay.

The same word also holds the two intermediate gray densities used in 2 bpp mode. Full black and full white are fixed and need no storage. The delays are copied into shadow registers at every line start. A write made in the middle of a line therefore changes nothing until the next line begins. The gray values are not shadowed and follow the register directly.

Top module: `panel_ctl_seq`

## Requirements
- R1: After reset, `cls`, `ps` and `rev` are 0 and `cfg_rdata` reads 0x040303A5. The outputs stay 0 whatever `lsclk_en` does until the first `line_start` pulse.
- R2: A write (`cfg_we`=1) stores `cfg_wdata`, and the new value reads back on `cfg_rdata` from the next cycle. The word layout is: bits 31:26 PS delay P, bits 23:16 CLS delay C, bits 15:8 REV delay R, bits 7:4 gray level 2, bits 3:0 gray level 1. Bits 25:24 are reserved and always read back as 0.
- R3: Let k be the number of `lsclk_en` pulses counted since the last `line_start`. `cls` is 1 exactly while C <= k < C+4 (CLS_HIGH = 4). With C = 0, `cls` goes high right after the line start.
- R4: `ps` is 0 from each line start and becomes 1 once k >= C+4+P. With P = 0, `ps` rises at the same count at which `cls` falls. `cls` and `ps` are never 1 together.
- R5: `rev` inverts exactly once per line, when k reaches R. With R = 0 it inverts right after the line start. Over successive lines this gives an alternating level.
- R6: C, P and R are sampled at each `line_start`. A write during a line does not change that line's timing and takes effect at the next line start.
- R7: `gray1` and `gray2` show bits 3:0 and 7:4 of the stored word, from the cycle after the write.
- R8: The pulse count saturates rather than wrapping. On an arbitrarily long line, `cls` stays 0, `ps` stays 1 and `rev` does not invert again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lsclk_en | input | 1 | One-cycle pulse per line-shift clock period |
| line_start | input | 1 | One-cycle pulse marking the start of a line |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback |
| cls | output | 1 | Line clock strobe |
| ps | output | 1 | Polarity-select strobe |
| rev | output | 1 | Line-alternating reversal signal |
| gray1 | output | 4 | First intermediate gray density |
| gray2 | output | 4 | Second intermediate gray density |

## Verification
The hardest case to reach from the ports is a write that lands in the middle of a line, while the edge it would move is still pending. The bench starts a line, lets one pulse pass, and then writes a much larger CLS delay. It checks that `cls` and `ps` still follow the old delay. It then starts a new line and checks the new delay. Saturation needs a line longer than the counter's range. The bench drives over 600 pulses without a line start and checks at every step that no edge returns.

// File: rtl/panel_ctl_pkg.sv
package panel_ctl_pkg;

    localparam int PSD_W  = 6;
    localparam int RSV_W  = 2;
    localparam int CLSD_W = 8;
    localparam int REVD_W = 8;
    localparam int GRAY_W = 4;
    localparam int REG_W  = PSD_W + RSV_W + CLSD_W + REVD_W + 2 * GRAY_W;

    typedef struct packed {
        logic [PSD_W-1:0]  ps_dly;
        logic [RSV_W-1:0]  rsv;
        logic [CLSD_W-1:0] cls_dly;
        logic [REVD_W-1:0] rev_dly;
        logic [GRAY_W-1:0] gray2;
        logic [GRAY_W-1:0] gray1;
    } cfg_t;

    typedef struct packed {
        logic [CLSD_W-1:0] cls;
        logic [PSD_W-1:0]  ps;
        logic [REVD_W-1:0] rev;
    } shadow_t;

    localparam cfg_t CFG_RESET = '{
        ps_dly:  PSD_W'(1),
        rsv:     '0,
        cls_dly: CLSD_W'(3),
        rev_dly: REVD_W'(3),
        gray2:   GRAY_W'(10),
        gray1:   GRAY_W'(5)
    };

endpackage

// File: rtl/panel_ctl_cfg.sv
module panel_ctl_cfg
    import panel_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output cfg_t             cfg
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d     = cfg_t'(wdata);
            cfg_d.rsv = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R2: reserved field never holds a one
    assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.rsv == '0);

    // R2: without a write the stored word holds
    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_q));

endmodule

// File: rtl/panel_ctl_timer.sv
module panel_ctl_timer
    import panel_ctl_pkg::*;
#(
    parameter int POS_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lsclk_en,
    input  logic              line_start,
    input  logic [CLSD_W-1:0] cls_dly,
    input  logic [PSD_W-1:0]  ps_dly,
    input  logic [REVD_W-1:0] rev_dly,
    output logic              armed,
    output logic [POS_W-1:0]  pos,
    output shadow_t           sh
);

    localparam logic [POS_W-1:0] POS_MAX = '1;

    typedef struct packed {
        logic             armed;
        logic [POS_W-1:0] pos;
        shadow_t          sh;
    } tstate_t;

    tstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (line_start) begin
            st_d.armed  = 1'b1;
            st_d.pos    = '0;
            st_d.sh.cls = cls_dly;
            st_d.sh.ps  = ps_dly;
            st_d.sh.rev = rev_dly;
        end else if (st_q.armed && lsclk_en && (st_q.pos != POS_MAX)) begin
            st_d.pos = st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed = st_q.armed;
    assign pos   = st_q.pos;
    assign sh    = st_q.sh;

    // R6: each line start restarts the count
    assert_pos_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (st_q.pos == '0));

    // R6: shadows change only at a line start
    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(st_q.sh));

    // R8: count moves by at most one and never wraps
    assert_pos_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> ((st_q.pos == $past(st_q.pos)) ||
                         ((st_q.pos > $past(st_q.pos)) &&
                          (st_q.pos - $past(st_q.pos) == POS_W'(1)))));

endmodule

// File: rtl/panel_ctl_sig.sv
module panel_ctl_sig
    import panel_ctl_pkg::*;
#(
    parameter int POS_W    = 9,
    parameter int CLS_HIGH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             armed,
    input  logic [POS_W-1:0] pos,
    input  shadow_t          sh,
    output logic             cls,
    output logic             ps,
    output logic             rev
);

    typedef struct packed {
        logic cls;
        logic ps;
        logic rev;
        logic rev_done;
    } sstate_t;

    sstate_t st_d, st_q;

    logic [POS_W-1:0] cls_rise;
    logic [POS_W-1:0] cls_fall;
    logic [POS_W-1:0] ps_rise;
    logic [POS_W-1:0] rev_at;

    always_comb begin
        cls_rise = POS_W'(sh.cls);
        cls_fall = cls_rise + POS_W'(CLS_HIGH);
        ps_rise  = cls_fall + POS_W'(sh.ps);
        rev_at   = POS_W'(sh.rev);

        st_d     = st_q;
        st_d.cls = armed && (pos >= cls_rise) && (pos < cls_fall);
        st_d.ps  = armed && (pos >= ps_rise);
        if (line_start) begin
            st_d.rev_done = 1'b0;
        end else if (armed && !st_q.rev_done && (pos == rev_at)) begin
            st_d.rev      = !st_q.rev;
            st_d.rev_done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cls = st_q.cls;
    assign ps  = st_q.ps;
    assign rev = st_q.rev;

    // R1: nothing moves before the first line start
    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (!st_q.cls && !st_q.ps && !st_q.rev));

    // R4: strobes are mutually exclusive
    assert_cls_ps_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.cls && st_q.ps));

    // R5: once flipped in a line, rev holds
    assert_rev_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rev_done && !line_start) |=> $stable(st_q.rev));

endmodule

// File: rtl/panel_ctl_seq.sv
module panel_ctl_seq
    import panel_ctl_pkg::*;
#(
    parameter int CLS_HIGH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lsclk_en,
    input  logic                line_start,
    input  logic                cfg_we,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    output logic                cls,
    output logic                ps,
    output logic                rev,
    output logic [GRAY_W-1:0]   gray1,
    output logic [GRAY_W-1:0]   gray2
);

    localparam int POS_W = $clog2((2 ** CLSD_W) + CLS_HIGH + (2 ** PSD_W) + 1);

    cfg_t             cfg;
    logic             armed;
    logic [POS_W-1:0] pos;
    shadow_t          sh;

    panel_ctl_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    panel_ctl_timer #(.POS_W(POS_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .lsclk_en   (lsclk_en),
        .line_start (line_start),
        .cls_dly    (cfg.cls_dly),
        .ps_dly     (cfg.ps_dly),
        .rev_dly    (cfg.rev_dly),
        .armed      (armed),
        .pos        (pos),
        .sh         (sh)
    );

    panel_ctl_sig #(.POS_W(POS_W), .CLS_HIGH(CLS_HIGH)) u_sig (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .armed      (armed),
        .pos        (pos),
        .sh         (sh),
        .cls        (cls),
        .ps         (ps),
        .rev        (rev)
    );

    assign cfg_rdata = cfg;
    assign gray1     = cfg.gray1;
    assign gray2     = cfg.gray2;

endmodule

// File: tb/panel_ctl_seq_tb_top.sv
module panel_ctl_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lsclk_en = 1'b0;
    logic        line_start = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cls, ps, rev;
    logic [3:0]  gray1, gray2;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    int m_c = 3, m_p = 1, m_r = 3;   // register fields
    int s_c = 0, s_p = 0, s_r = 0;   // shadows
    int k = 0;
    logic rev_exp = 1'b0;

    always #2.5 clk = ~clk;

    panel_ctl_seq dut_i (
        .clk(clk), .rst_n(rst_n), .lsclk_en(lsclk_en), .line_start(line_start),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cls(cls), .ps(ps), .rev(rev), .gray1(gray1), .gray2(gray2)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic check_outs(input string req);
        logic ec, ep;
        ec = (k >= s_c) && (k < s_c + 4);
        ep = (k >= s_c + 4 + s_p);
        chk(req, "cls", {31'b0, cls}, {31'b0, ec});
        chk(req, "ps",  {31'b0, ps},  {31'b0, ep});
        chk(req, "rev", {31'b0, rev}, {31'b0, rev_exp});
    endtask

    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        m_p = int'(w[31:26]); m_c = int'(w[23:16]); m_r = int'(w[15:8]);
    endtask

    task automatic ls_pulse();
        @(negedge clk);
        lsclk_en = 1'b1;
        @(negedge clk);
        lsclk_en = 1'b0;
        settle();
    endtask

    task automatic line_go();
        @(negedge clk);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        settle();
        s_c = m_c; s_p = m_p; s_r = m_r; k = 0;
        if (s_r == 0) rev_exp = ~rev_exp;
    endtask

    task automatic step();
        ls_pulse();
        k++;
        if (k == s_r) rev_exp = ~rev_exp;
    endtask

    task automatic t_reset();
        chk("R1", "cls", {31'b0, cls}, 32'h0);
        chk("R1", "ps",  {31'b0, ps},  32'h0);
        chk("R1", "rev", {31'b0, rev}, 32'h0);
        chk("R1", "rdata", cfg_rdata, 32'h040303A5);
        for (int i = 0; i < 6; i++) ls_pulse();
        chk("R1", "cls idle", {31'b0, cls}, 32'h0);
        chk("R1", "ps idle",  {31'b0, ps},  32'h0);
        chk("R1", "rev idle", {31'b0, rev}, 32'h0);
    endtask

    task automatic t_regs();
        write_cfg(32'hFFFF_FFFF);
        chk("R2", "rsv masked", cfg_rdata, 32'hFCFF_FFFF);
        write_cfg({6'd1, 2'b11, 8'd2, 8'd3, 4'h6, 4'h9});
        chk("R2", "readback", cfg_rdata, {6'd1, 2'b00, 8'd2, 8'd3, 4'h6, 4'h9});
        chk("R7", "gray1", {28'b0, gray1}, 32'h9);
        chk("R7", "gray2", {28'b0, gray2}, 32'h6);
    endtask

    task automatic t_line_basic();
        for (int ln = 0; ln < 2; ln++) begin
            line_go();
            check_outs("R3");
            for (int i = 0; i < 12; i++) begin
                step();
                check_outs((k == s_r) ? "R5" : "R4");
            end
        end
    endtask

    task automatic t_zero_delays();
        write_cfg({6'd0, 2'b00, 8'd0, 8'd0, 4'h1, 4'h2});
        line_go();
        chk("R3", "cls at k0", {31'b0, cls}, 32'h1);
        check_outs("R5");
        for (int i = 0; i < 6; i++) begin
            step();
            check_outs("R4");
        end
    endtask

    task automatic t_shadow();
        write_cfg({6'd2, 2'b00, 8'd2, 8'd4, 4'h1, 4'h2});
        line_go();
        step();
        write_cfg({6'd0, 2'b00, 8'd7, 8'd1, 4'h1, 4'h2});
        check_outs("R6");
        for (int i = 0; i < 10; i++) begin
            step();
            check_outs("R6");
        end
        line_go();
        check_outs("R6");
        for (int i = 0; i < 12; i++) begin
            step();
            check_outs("R6");
        end
    endtask

    task automatic t_saturate();
        write_cfg({6'd63, 2'b00, 8'd255, 8'd255, 4'h3, 4'h4});
        line_go();
        for (int i = 0; i < 640; i++) begin
            step();
            if (k >= 320) check_outs("R8");
        end
        chk("R8", "ps held", {31'b0, ps}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_regs();
        t_line_basic();
        t_zero_delays();
        t_shadow();
        t_saturate();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule